// File: doc/BRIEF.md
# Accumulator Shift, Round and Saturate Unit

This unit carries out the shift instruction group of a small fixed-point signal processor. It holds a bank of wide accumulators. Each accumulator keeps a product-width field of two data words plus a set of guard bits above it. When the instruction decode sees the shift group, a four-bit operation code selects one of two kinds of work. A register form moves, rotates, rounds or truncates the chosen accumulator in place. A memory form reduces the accumulator to one data byte and issues a single-cycle store request to a 16-bit address. It can reduce the value by truncation, by rounding or by saturation, and it can read the accumulator either as an integer or as a fraction.

The surrounding datapath writes accumulators through a load port and reads any accumulator through a combinational peek port. The carry flag records the last bit pushed out by a shift or rotate. The saturation flag records whether the last saturating store had to clip. The memory itself, the arithmetic group and the multiplier live outside this block.

Top module: `acc_shift_limit`

## Requirements
- R1: An instruction takes effect only when `instr_valid` is high, `major_op` is 3'b010 and `func_code` is 5'b11111. It acts on the accumulator chosen by `acc_sel` and leaves every other accumulator alone.
- R2: Code 4'b0000 shifts left one bit and fills with zero. Code 4'b0001 shifts right one bit and copies the sign. Code 4'b0010 shifts right one bit and fills with zero. In each case the bit pushed out lands in `carry`.
- R3: Code 4'b0011 rotates left and code 4'b0100 rotates right, both by one bit across the full accumulator width. The bit that wraps around is copied into `carry`.
- R4: Code 4'b0101 adds 2^(DW-1) to the accumulator and then clears its low DW bits. Code 4'b0110 clears the low DW bits and adds nothing. Neither code changes `carry`.
- R5: A memory form (codes 4'b1000 to 4'b1101) raises `st_we` for exactly one cycle after the sampling edge. In that cycle `st_addr` equals the displacement and `st_data` holds the byte. The accumulators and `carry` stay unchanged.
- R6: Code 4'b1000 saturates the integer byte (bits DW-1:0). Code 4'b1001 saturates the fraction byte (bits 2DW-1:DW). The unit clips when the bits above the byte's sign bit differ from that sign bit. It then stores 8'h7F if the accumulator's MSB is 0 and 8'h80 if it is 1. The `sat` flag takes the clip result of every saturating store.
- R7: Code 4'b1010 stores the integer byte unchanged. Code 4'b1011 stores the fraction byte with the lower bits dropped.
- R8: Code 4'b1100 stores the integer byte, which has no lower bits to round. Code 4'b1101 stores the fraction byte plus accumulator bit DW-1, so it rounds half up and wraps at the byte width.
- R9: Codes 4'b0111, 4'b1110 and 4'b1111 change no accumulator and no flag, and they raise no store.
- R10: After reset, all accumulators, `carry`, `sat` and `st_we` are zero.
- R11: `load_en` writes `load_val` into accumulator `load_sel` at the next edge. It wins over an in-place operation on the same accumulator in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction present this cycle |
| major_op | input | 3 | Major opcode |
| func_code | input | 5 | Function field |
| acc_sel | input | 2 | Target accumulator |
| shift_op | input | 4 | Operation code within the shift group |
| disp | input | 16 | Store displacement |
| load_en | input | 1 | Accumulator write enable |
| load_sel | input | 2 | Accumulator to write |
| load_val | input | 20 | Value to write |
| peek_sel | input | 2 | Accumulator to read |
| peek_val | output | 20 | Selected accumulator contents |
| carry | output | 1 | Last bit shifted or rotated out |
| sat | output | 1 | Last saturating store clipped |
| st_we | output | 1 | Store request strobe |
| st_addr | output | 16 | Store address |
| st_data | output | 8 | Store byte |

## Verification
Every result sits in a register that loads on the edge that samples the instruction. So the accumulator, both flags and the store request all become visible one cycle after the instruction is presented. The store strobe must drop again one cycle after that. The bench drives inputs on falling edges and reads the peek port and the store outputs on the next falling edge after the capturing edge. It looks one more falling edge later to confirm that the strobe has cleared.

// File: rtl/asl_pkg.sv
package asl_pkg;

    localparam logic [2:0] SHIFT_MAJOR = 3'b010;
    localparam logic [4:0] SHIFT_FUNC  = 5'b11111;

    typedef enum logic [3:0] {
        SH_ALEFT     = 4'b0000,
        SH_ARIGHT    = 4'b0001,
        SH_LRIGHT    = 4'b0010,
        SH_ROTL      = 4'b0011,
        SH_ROTR      = 4'b0100,
        SH_ROUND     = 4'b0101,
        SH_TRUNC     = 4'b0110,
        ST_SATINT    = 4'b1000,
        ST_SATFRAC   = 4'b1001,
        ST_TRUNCINT  = 4'b1010,
        ST_TRUNCFRAC = 4'b1011,
        ST_ROUNDINT  = 4'b1100,
        ST_ROUNDFRAC = 4'b1101
    } shop_e;

endpackage

// File: rtl/asl_decode.sv
module asl_decode
    import asl_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] major,
    input  logic [4:0] func,
    input  logic [3:0] code,
    output logic       group_hit,
    output logic       reg_form,
    output logic       mem_form
);

    always_comb begin
        group_hit = valid && (major == SHIFT_MAJOR) && (func == SHIFT_FUNC);
        reg_form  = 1'b0;
        mem_form  = 1'b0;
        case (code)
            SH_ALEFT, SH_ARIGHT, SH_LRIGHT, SH_ROTL, SH_ROTR,
            SH_ROUND, SH_TRUNC:
                reg_form = group_hit;
            ST_SATINT, ST_SATFRAC, ST_TRUNCINT, ST_TRUNCFRAC,
            ST_ROUNDINT, ST_ROUNDFRAC:
                mem_form = group_hit;
            default: ;
        endcase
    end

endmodule

// File: rtl/asl_shift.sv
module asl_shift
    import asl_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic [AW-1:0] acc_in,
    input  logic [3:0]    code,
    input  logic          carry_in,
    output logic [AW-1:0] acc_out,
    output logic          carry_out
);

    localparam logic [AW-1:0] HALF_LSB = AW'(1) << (DW - 1);
    localparam logic [AW-1:0] LOW_MASK = (AW'(1) << DW) - AW'(1);

    always_comb begin
        acc_out   = acc_in;
        carry_out = carry_in;
        case (code)
            SH_ALEFT: begin
                acc_out   = {acc_in[AW-2:0], 1'b0};
                carry_out = acc_in[AW-1];
            end
            SH_ARIGHT: begin
                acc_out   = {acc_in[AW-1], acc_in[AW-1:1]};
                carry_out = acc_in[0];
            end
            SH_LRIGHT: begin
                acc_out   = {1'b0, acc_in[AW-1:1]};
                carry_out = acc_in[0];
            end
            SH_ROTL: begin
                acc_out   = {acc_in[AW-2:0], acc_in[AW-1]};
                carry_out = acc_in[AW-1];
            end
            SH_ROTR: begin
                acc_out   = {acc_in[0], acc_in[AW-1:1]};
                carry_out = acc_in[0];
            end
            SH_ROUND: acc_out = (acc_in + HALF_LSB) & ~LOW_MASK;
            SH_TRUNC: acc_out = acc_in & ~LOW_MASK;
            default: ;
        endcase
    end

endmodule

// File: rtl/asl_cond.sv
module asl_cond
    import asl_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic [AW-1:0] acc,
    input  logic [3:0]    code,
    output logic [DW-1:0] data,
    output logic          is_limit,
    output logic          clip
);

    localparam int FLO = DW;
    localparam int FHI = 2 * DW - 1;
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic [AW-DW:0]  int_top;
    logic [AW-FHI-1:0] frac_top;
    logic            int_fits;
    logic            frac_fits;
    logic [DW-1:0]   clip_val;
    logic [DW-1:0]   frac_rnd;

    always_comb begin
        int_top   = acc[AW-1:DW-1];
        frac_top  = acc[AW-1:FHI];
        int_fits  = (&int_top) | ~(|int_top);
        frac_fits = (&frac_top) | ~(|frac_top);
        clip_val  = acc[AW-1] ? NEG_LIM : POS_LIM;
        frac_rnd  = acc[FHI:FLO] + DW'(acc[DW-1]);

        data     = acc[DW-1:0];
        is_limit = 1'b0;
        clip     = 1'b0;
        case (code)
            ST_SATINT: begin
                is_limit = 1'b1;
                clip     = !int_fits;
                data     = int_fits ? acc[DW-1:0] : clip_val;
            end
            ST_SATFRAC: begin
                is_limit = 1'b1;
                clip     = !frac_fits;
                data     = frac_fits ? acc[FHI:FLO] : clip_val;
            end
            ST_TRUNCFRAC: data = acc[FHI:FLO];
            ST_ROUNDFRAC: data = frac_rnd;
            default:      data = acc[DW-1:0];
        endcase
    end

endmodule

// File: rtl/acc_shift_limit.sv
module acc_shift_limit
    import asl_pkg::*;
#(
    parameter int DW    = 8,
    parameter int GW    = 4,
    parameter int NACC  = 4,
    parameter int ADDRW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_valid,
    input  logic [2:0]                   major_op,
    input  logic [4:0]                   func_code,
    input  logic [$clog2(NACC)-1:0]      acc_sel,
    input  logic [3:0]                   shift_op,
    input  logic [ADDRW-1:0]             disp,
    input  logic                         load_en,
    input  logic [$clog2(NACC)-1:0]      load_sel,
    input  logic [GW+2*DW-1:0]           load_val,
    input  logic [$clog2(NACC)-1:0]      peek_sel,
    output logic [GW+2*DW-1:0]           peek_val,
    output logic                         carry,
    output logic                         sat,
    output logic                         st_we,
    output logic [ADDRW-1:0]             st_addr,
    output logic [DW-1:0]                st_data
);

    localparam int AW = GW + 2 * DW;
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NACC-1:0][AW-1:0] acc;
        logic                    carry;
        logic                    sat;
        logic                    we;
        logic [ADDRW-1:0]        addr;
        logic [DW-1:0]           data;
    } state_t;

    state_t st_d, st_q;

    logic          dec_group, dec_reg, dec_mem;
    logic [AW-1:0] sel_acc;
    logic [AW-1:0] sh_acc;
    logic          sh_carry;
    logic [DW-1:0] cd_data;
    logic          cd_limit, cd_clip;

    assign sel_acc = st_q.acc[acc_sel];

    asl_decode u_decode (
        .valid     (instr_valid),
        .major     (major_op),
        .func      (func_code),
        .code      (shift_op),
        .group_hit (dec_group),
        .reg_form  (dec_reg),
        .mem_form  (dec_mem)
    );

    asl_shift #(.DW(DW), .AW(AW)) u_shift (
        .acc_in    (sel_acc),
        .code      (shift_op),
        .carry_in  (st_q.carry),
        .acc_out   (sh_acc),
        .carry_out (sh_carry)
    );

    asl_cond #(.DW(DW), .AW(AW)) u_cond (
        .acc      (sel_acc),
        .code     (shift_op),
        .data     (cd_data),
        .is_limit (cd_limit),
        .clip     (cd_clip)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (dec_reg) begin
            st_d.acc[acc_sel] = sh_acc;
            st_d.carry        = sh_carry;
        end
        if (dec_mem) begin
            st_d.we   = 1'b1;
            st_d.addr = disp;
            st_d.data = cd_data;
            if (cd_limit) begin
                st_d.sat = cd_clip;
            end
        end
        if (load_en) begin
            st_d.acc[load_sel] = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign peek_val = st_q.acc[peek_sel];
    assign carry    = st_q.carry;
    assign sat      = st_q.sat;
    assign st_we    = st_q.we;
    assign st_addr  = st_q.addr;
    assign st_data  = st_q.data;

    AST_STROBE_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> $past(dec_mem)); // R5
    AST_STORE_RAISES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_mem |=> st_we); // R5
    AST_ADDR_FROM_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (st_addr == $past(disp))); // R5
    AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mem && !load_en) |=> ($stable(st_q.acc) && $stable(carry))); // R5
    AST_CLIP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat) |-> (st_we && (st_data == POS_LIM || st_data == NEG_LIM))); // R6
    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_group && !dec_reg && !dec_mem && !load_en)
            |=> (!st_we && $stable(st_q.acc) && $stable(carry) && $stable(sat))); // R9
    AST_OUTSIDE_GROUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_group && !load_en) |=> (!st_we && $stable(st_q.acc) && $stable(carry))); // R1

endmodule

// File: tb/acc_shift_limit_tb.sv
module acc_shift_limit_tb;

    typedef struct packed {
        logic [3:0]  code;
        logic [19:0] init;
        logic [19:0] acc;
        logic        c_chk;
        logic        c_exp;
        logic        we;
        logic [7:0]  data;
        logic        s_chk;
        logic        s_exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 20'h80001, 20'h00002, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R2
        '{4'h0, 20'h12345, 20'h2468A, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R2
        '{4'h1, 20'h80003, 20'hC0001, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R2
        '{4'h1, 20'h40002, 20'h20001, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R2
        '{4'h2, 20'h80003, 20'h40001, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R2
        '{4'h3, 20'h80001, 20'h00003, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R3
        '{4'h4, 20'h00003, 20'h80001, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R3
        '{4'h4, 20'h00002, 20'h00001, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3
        '{4'h5, 20'h00180, 20'h00200, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4
        '{4'h5, 20'h0017F, 20'h00100, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4
        '{4'h6, 20'h001FF, 20'h00100, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4
        '{4'h5, 20'hFFF80, 20'h00000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4
        '{4'h8, 20'h0007F, 20'h0007F, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0}, // R6
        '{4'h8, 20'h00080, 20'h00080, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b1}, // R6
        '{4'h8, 20'hFFF7F, 20'hFFF7F, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1}, // R6
        '{4'h8, 20'hFFF80, 20'hFFF80, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0}, // R6
        '{4'h9, 20'h07F00, 20'h07F00, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0}, // R6
        '{4'h9, 20'h08000, 20'h08000, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b1}, // R6
        '{4'h9, 20'hF7FFF, 20'hF7FFF, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1}, // R6
        '{4'hA, 20'h12345, 20'h12345, 1'b0, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0}, // R7
        '{4'hB, 20'h12345, 20'h12345, 1'b0, 1'b0, 1'b1, 8'h23, 1'b0, 1'b0}, // R7
        '{4'hC, 20'h123FF, 20'h123FF, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0}, // R8
        '{4'hD, 20'h12380, 20'h12380, 1'b0, 1'b0, 1'b1, 8'h24, 1'b0, 1'b0}, // R8
        '{4'hD, 20'h1237F, 20'h1237F, 1'b0, 1'b0, 1'b1, 8'h23, 1'b0, 1'b0}, // R8
        '{4'h7, 20'h12345, 20'h12345, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R9
        '{4'hE, 20'h12345, 20'h12345, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R9
        '{4'hF, 20'h12345, 20'h12345, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  major_op = '0;
    logic [4:0]  func_code = '0;
    logic [1:0]  acc_sel = '0;
    logic [3:0]  shift_op = '0;
    logic [15:0] disp = '0;
    logic        load_en = 1'b0;
    logic [1:0]  load_sel = '0;
    logic [19:0] load_val = '0;
    logic [1:0]  peek_sel = '0;
    logic [19:0] peek_val;
    logic        carry, sat, st_we;
    logic [15:0] st_addr;
    logic [7:0]  st_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    acc_shift_limit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .major_op(major_op),
        .func_code(func_code), .acc_sel(acc_sel), .shift_op(shift_op), .disp(disp),
        .load_en(load_en), .load_sel(load_sel), .load_val(load_val),
        .peek_sel(peek_sel), .peek_val(peek_val), .carry(carry), .sat(sat),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] c);
        if (c <= 4'h2) return "R2";
        if (c <= 4'h4) return "R3";
        if (c <= 4'h6) return "R4";
        if (c == 4'h8 || c == 4'h9) return "R6";
        if (c == 4'hA || c == 4'hB) return "R7";
        if (c == 4'hC || c == 4'hD) return "R8";
        return "R9";
    endfunction

    task automatic peek(input logic [1:0] s, output logic [19:0] v);
        peek_sel = s;
        #1;
        v = peek_val;
    endtask

    task automatic load(input logic [1:0] s, input logic [19:0] v);
        load_en = 1'b1; load_sel = s; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic issue(input logic [2:0] mj, input logic [4:0] fn, input logic [1:0] s,
                         input logic [3:0] c, input logic [15:0] d, input logic v);
        instr_valid = v; major_op = mj; func_code = fn; acc_sel = s; shift_op = c; disp = d;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [19:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk("R10", "acc after reset", 32'(v), 32'h0);
        end
        chk("R10", "carry after reset", 32'(carry), 32'h0);
        chk("R10", "sat after reset", 32'(sat), 32'h0);
        chk("R10", "strobe after reset", 32'(st_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load(2'd0, VECS[i].init);
            issue(3'b010, 5'b11111, 2'd0, VECS[i].code, 16'hA000 + 16'(i), 1'b1);
            peek(2'd0, v);
            chk(req_of(VECS[i].code), "accumulator", 32'(v), 32'(VECS[i].acc));
            chk(VECS[i].we ? "R5" : req_of(VECS[i].code), "strobe",
                32'(st_we), 32'(VECS[i].we));
            if (VECS[i].we) begin
                chk(req_of(VECS[i].code), "store byte", 32'(st_data), 32'(VECS[i].data));
                chk("R5", "store address", 32'(st_addr), 32'(16'hA000 + 16'(i)));
            end
            if (VECS[i].c_chk) chk(req_of(VECS[i].code), "carry", 32'(carry), 32'(VECS[i].c_exp));
            if (VECS[i].s_chk) chk("R6", "sat flag", 32'(sat), 32'(VECS[i].s_exp));
            @(negedge clk);
            chk("R5", "strobe one cycle", 32'(st_we), 32'h0);
        end

        // R1: wrong major opcode, wrong function field, no valid
        load(2'd1, 20'h12345);
        issue(3'b000, 5'b11111, 2'd1, 4'h0, 16'h0, 1'b1);
        peek(2'd1, v);
        chk("R1", "wrong major ignored", 32'(v), 32'h12345);
        chk("R1", "wrong major no strobe", 32'(st_we), 32'h0);
        issue(3'b010, 5'b11110, 2'd1, 4'h0, 16'h0, 1'b1);
        peek(2'd1, v);
        chk("R1", "wrong func ignored", 32'(v), 32'h12345);
        issue(3'b010, 5'b11111, 2'd1, 4'h8, 16'h0, 1'b0);
        chk("R1", "no valid no strobe", 32'(st_we), 32'h0);
        issue(3'b010, 5'b11111, 2'd1, 4'h0, 16'h0, 1'b1);
        peek(2'd1, v);
        chk("R1", "selected acc shifted", 32'(v), 32'h2468A);
        peek(2'd0, v);
        chk("R1", "other acc untouched", 32'(v), 32'h12345);

        // R11: load wins over same-cycle operation on same accumulator
        load_en = 1'b1; load_sel = 2'd2; load_val = 20'h00001;
        issue(3'b010, 5'b11111, 2'd2, 4'h0, 16'h0, 1'b1);
        load_en = 1'b0;
        peek(2'd2, v);
        chk("R11", "load priority", 32'(v), 32'h00001);

        // R5: store keeps carry and accumulator
        load(2'd3, 20'h80000);
        issue(3'b010, 5'b11111, 2'd3, 4'h0, 16'h0, 1'b1);
        chk("R2", "carry set by shift", 32'(carry), 32'h1);
        issue(3'b010, 5'b11111, 2'd3, 4'h8, 16'h5A5A, 1'b1);
        peek(2'd3, v);
        chk("R5", "carry held by store", 32'(carry), 32'h1);
        chk("R5", "acc held by store", 32'(v), 32'h0);
        chk("R6", "sat cleared", 32'(sat), 32'h0);
        chk("R5", "address", 32'(st_addr), 32'h5A5A);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule